// File: doc/BRIEF.md
# Two-Wire Serial Register Slave

This block lets a host controller reach a bank of 8-bit control registers, and a range of externally supplied status bytes, over a two-wire serial bus made of a clock line and a data line. A system clock samples both lines through a synchroniser. The block detects the bus conditions that open and close a transfer, and it shifts in bytes most significant bit first. It accepts one fixed byte value that selects a write and a second fixed byte value that selects a read.

In a write, the byte after the device byte loads a register pointer. Each data byte after that goes to the register the pointer selects, and the pointer then advances by one. In a read, the host first sets the pointer with a write, closes the bus, and reopens it with the read device byte. The block then streams consecutive registers. The acknowledge and all read data leave on a dedicated output pin and never on the data line. Read data on that pin is bit-inverted.

Writable registers occupy the low `NUM_RW` addresses and reset to `RST_SEED + index`. Each accepted write gives a one-cycle strobe with its address and data, so neighbouring logic can react. Higher addresses are read through `rd_addr_o` and `rd_data_i`, and writes to them are dropped.

Top module: `tw_serial_slave`

## Requirements
- R1: After reset `ack_o` is 1, no write strobe is given, and writable register i holds `RST_SEED + i` (with defaults, 0x20 + i).
- R2: A high-to-low data edge while the clock is high opens a transfer. A low-to-high data edge while the clock is high closes it, returns the block to idle and sets `ack_o` to 1. Clock pulses after a close change no register, and `ack_o` stays 1.
- R3: Device byte 0x24 (write) and 0x25 (read) are acknowledged by `ack_o` = 0 while the clock is high in the 9th clock. Any other device byte gets no acknowledge, and the bytes that follow it are ignored until the next opening condition.
- R4: Each byte is 9 clocks long: 8 data bits, most significant first, sampled on the rising clock edge, then one acknowledge slot. In a write, every pointer byte and data byte is acknowledged with `ack_o` = 0 in its 9th clock.
- R5: In a write, the first byte after the device byte sets the pointer. Each following byte is written to the pointed register, and the pointer then increments. Each write to a writable address gives exactly one `wr_stb_o` pulse of one cycle, carrying `wr_addr_o` and `wr_data_o`, and updates the matching byte of `cfg_o`.
- R6: Addresses `NUM_RW` to 0xFF (with defaults, 0x20 to 0xFF) are read-only. A write to them gives no strobe and changes no register, but it is still acknowledged and still advances the pointer. The pointer wraps from 0xFF to 0x00.
- R7: In a read, bytes come from consecutive addresses starting at the pointer. Each byte appears on `ack_o` inverted and most significant bit first, and the first bit is presented at the falling clock edge that ends the address acknowledge. `ack_o` is 1 during the host acknowledge slot. Addresses below `NUM_RW` read the register bank. Higher addresses read `rd_data_i`, with `rd_addr_o` showing the address.
- R8: During a read, the host drives the data line low in the acknowledge slot to continue. If the host leaves it high, the read ends, and `ack_o` stays 1 on later clock pulses until the next opening condition.
- R9: An opening condition in the middle of a byte abandons the current transfer and restarts device byte reception. The partial byte has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Serial clock line from the host |
| sda_i | input | 1 | Serial data line from the host |
| ack_o | output | 1 | Acknowledge and inverted readback pin; 1 when released |
| wr_stb_o | output | 1 | One-cycle pulse for each accepted register write |
| wr_addr_o | output | 8 | Address of the accepted write |
| wr_data_o | output | 8 | Data of the accepted write |
| rd_addr_o | output | 8 | Current pointer, used to select external read data |
| rd_data_i | input | 8 | Read data for addresses at or above NUM_RW |
| cfg_o | output | NUM_RW*8 | Contents of the writable registers, register i at bits [8i+7:8i] |

## Verification
The assertions assume that the host changes the data line only while the clock is low, that the change lands several system clocks away from any clock edge, and that every clock phase lasts longer than the synchroniser delay. Only under these conditions does each opening or closing condition, and each clock edge, reach the control logic as a single clean event. The bench keeps every bus phase ten system clocks long and moves the data line only in the middle of a low clock phase. Its abort and close cases create start and stop conditions on purpose, with the clock held high.

// File: rtl/tw_pkg.sv
package tw_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_DEV,
        ST_PTR,
        ST_WR,
        ST_RD
    } tw_st_e;

    // bit counter values: 8 = byte shifted in, 9 = acknowledge slot
    localparam logic [3:0] CNT_BYTE = 4'd8;
    localparam logic [3:0] CNT_ACK  = 4'd9;

    typedef struct packed {
        tw_st_e      st;
        tw_st_e      nxt;
        logic [3:0]  cnt;
        logic [7:0]  sh;
        logic [7:0]  ptr;
        logic        ack;
        logic        mnack;
        logic        stb;
        logic [7:0]  waddr;
        logic [7:0]  wdata;
    } tw_ctl_t;

endpackage

// File: rtl/tw_pin_cond.sv
module tw_pin_cond #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_rise,
    output logic scl_fall,
    output logic sda_lvl,
    output logic start_det,
    output logic stop_det
);
    logic [1:0] pin_in;
    logic [1:0] lvl;
    logic [1:0] prv;

    assign pin_in = {sda_i, scl_i};

    // index 0 = clock line, index 1 = data line
    for (genvar g = 0; g < 2; g++) begin : g_line
        logic [STAGES:0] chain_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain_q <= '1;
            else        chain_q <= {chain_q[STAGES-1:0], pin_in[g]};
        end
        assign lvl[g] = chain_q[STAGES-1];
        assign prv[g] = chain_q[STAGES];
    end

    assign scl_rise  = lvl[0] & ~prv[0];
    assign scl_fall  = ~lvl[0] & prv[0];
    assign sda_lvl   = lvl[1];
    assign start_det = lvl[0] & prv[0] & prv[1] & ~lvl[1];
    assign stop_det  = lvl[0] & prv[0] & ~prv[1] & lvl[1];

endmodule

// File: rtl/tw_reg_bank.sv
module tw_reg_bank #(
    parameter int         NUM_RW   = 32,
    parameter int         IDX_W    = 5,
    parameter logic [7:0] RST_SEED = 8'h20
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  we,
    input  logic [IDX_W-1:0]      waddr,
    input  logic [7:0]            wdata,
    input  logic [IDX_W-1:0]      raddr,
    output logic [7:0]            rdata,
    output logic [NUM_RW*8-1:0]   cfg
);
    for (genvar i = 0; i < NUM_RW; i++) begin : g_reg
        logic [7:0] val_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                                  val_q <= 8'(int'(RST_SEED) + i);
            else if (we && (waddr == IDX_W'(i)))         val_q <= wdata;
        end
        assign cfg[i*8 +: 8] = val_q;
    end

    assign rdata = cfg[int'(raddr)*8 +: 8];

endmodule

// File: rtl/tw_serial_slave.sv
module tw_serial_slave #(
    parameter int         NUM_RW      = 32,
    parameter logic [6:0] DEV_ID      = 7'h12,
    parameter logic [7:0] RST_SEED    = 8'h20,
    parameter int         SYNC_STAGES = 2
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  scl_i,
    input  logic                  sda_i,
    output logic                  ack_o,
    output logic                  wr_stb_o,
    output logic [7:0]            wr_addr_o,
    output logic [7:0]            wr_data_o,
    output logic [7:0]            rd_addr_o,
    input  logic [7:0]            rd_data_i,
    output logic [NUM_RW*8-1:0]   cfg_o
);
    import tw_pkg::*;

    localparam int         IDX_W   = $clog2(NUM_RW);
    localparam logic [8:0] RW_LIM  = 9'(NUM_RW);
    localparam logic [7:0] WR_BYTE = {DEV_ID, 1'b0};
    localparam logic [7:0] RD_BYTE = {DEV_ID, 1'b1};

    localparam tw_ctl_t CTL_RST = '{st: ST_IDLE, nxt: ST_IDLE, cnt: 4'd0, sh: 8'd0,
                                    ptr: 8'd0, ack: 1'b1, mnack: 1'b0, stb: 1'b0,
                                    waddr: 8'd0, wdata: 8'd0};

    logic       scl_rise, scl_fall, sda_lvl, start_det, stop_det;
    logic [7:0] bank_rd, rd_val;
    logic       idle_s;
    tw_ctl_t    ctl_d, ctl_q;

    tw_pin_cond #(.STAGES(SYNC_STAGES)) u_pins (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_i     (scl_i),
        .sda_i     (sda_i),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .sda_lvl   (sda_lvl),
        .start_det (start_det),
        .stop_det  (stop_det)
    );

    tw_reg_bank #(.NUM_RW(NUM_RW), .IDX_W(IDX_W), .RST_SEED(RST_SEED)) u_bank (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (ctl_q.stb),
        .waddr (ctl_q.waddr[IDX_W-1:0]),
        .wdata (ctl_q.wdata),
        .raddr (ctl_q.ptr[IDX_W-1:0]),
        .rdata (bank_rd),
        .cfg   (cfg_o)
    );

    assign rd_val = ({1'b0, ctl_q.ptr} < RW_LIM) ? bank_rd : rd_data_i;

    always_comb begin
        ctl_d     = ctl_q;
        ctl_d.stb = 1'b0;
        if (start_det) begin
            ctl_d.st  = ST_DEV;
            ctl_d.cnt = 4'd0;
            ctl_d.ack = 1'b1;
        end else if (stop_det) begin
            ctl_d.st  = ST_IDLE;
            ctl_d.cnt = 4'd0;
            ctl_d.ack = 1'b1;
        end else if (ctl_q.st != ST_IDLE) begin
            if (scl_rise) begin
                if (ctl_q.cnt < CNT_BYTE) begin
                    ctl_d.cnt = ctl_q.cnt + 4'd1;
                    if (ctl_q.st != ST_RD) ctl_d.sh = {ctl_q.sh[6:0], sda_lvl};
                end else if (ctl_q.cnt == CNT_ACK && ctl_q.st == ST_RD) begin
                    ctl_d.mnack = sda_lvl;
                end
            end else if (scl_fall) begin
                if (ctl_q.cnt == CNT_BYTE) begin
                    ctl_d.cnt = CNT_ACK;
                    case (ctl_q.st)
                        ST_DEV: begin
                            if (ctl_q.sh == WR_BYTE) begin
                                ctl_d.ack = 1'b0;
                                ctl_d.nxt = ST_PTR;
                            end else if (ctl_q.sh == RD_BYTE) begin
                                ctl_d.ack   = 1'b0;
                                ctl_d.nxt   = ST_RD;
                                ctl_d.mnack = 1'b0;
                            end else begin
                                ctl_d.st = ST_IDLE;
                            end
                        end
                        ST_PTR: begin
                            ctl_d.ptr = ctl_q.sh;
                            ctl_d.ack = 1'b0;
                            ctl_d.nxt = ST_WR;
                        end
                        ST_WR: begin
                            if ({1'b0, ctl_q.ptr} < RW_LIM) begin
                                ctl_d.stb   = 1'b1;
                                ctl_d.waddr = ctl_q.ptr;
                                ctl_d.wdata = ctl_q.sh;
                            end
                            ctl_d.ptr = ctl_q.ptr + 8'd1;
                            ctl_d.ack = 1'b0;
                            ctl_d.nxt = ST_WR;
                        end
                        default: begin
                            ctl_d.ack = 1'b1;
                            ctl_d.nxt = ST_RD;
                        end
                    endcase
                end else if (ctl_q.cnt == CNT_ACK) begin
                    ctl_d.cnt = 4'd0;
                    ctl_d.ack = 1'b1;
                    ctl_d.st  = ctl_q.nxt;
                    if (ctl_q.nxt == ST_RD) begin
                        if (ctl_q.mnack) begin
                            ctl_d.st = ST_IDLE;
                        end else begin
                            ctl_d.sh  = rd_val;
                            ctl_d.ptr = ctl_q.ptr + 8'd1;
                            ctl_d.ack = ~rd_val[7];
                        end
                    end
                end else if (ctl_q.st == ST_RD && ctl_q.cnt != 4'd0) begin
                    ctl_d.sh  = {ctl_q.sh[6:0], 1'b0};
                    ctl_d.ack = ~ctl_d.sh[7];
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctl_q <= CTL_RST;
        else        ctl_q <= ctl_d;
    end

    assign ack_o     = ctl_q.ack;
    assign wr_stb_o  = ctl_q.stb;
    assign wr_addr_o = ctl_q.waddr;
    assign wr_data_o = ctl_q.wdata;
    assign rd_addr_o = ctl_q.ptr;
    assign idle_s    = (ctl_q.st == ST_IDLE);

endmodule

// File: rtl/tw_serial_slave_chk.sv
module tw_serial_slave_chk #(
    parameter int NUM_RW = 32
) (
    input logic       clk,
    input logic       rst_n,
    input logic       ack_o,
    input logic       wr_stb_o,
    input logic [7:0] wr_addr_o,
    input logic       scl_fall,
    input logic       start_det,
    input logic       stop_det,
    input logic       idle_s
);
    // R5: a write strobe lasts exactly one cycle
    a_r5_strobe_single: assert property (@(posedge clk) disable iff (!rst_n)
        wr_stb_o |=> !wr_stb_o);

    // R6: strobes only name writable addresses
    a_r6_strobe_rw_only: assert property (@(posedge clk) disable iff (!rst_n)
        wr_stb_o |-> ({1'b0, wr_addr_o} < 9'(NUM_RW)));

    // R2: a closing condition releases the pin and idles the block
    a_r2_stop_releases: assert property (@(posedge clk) disable iff (!rst_n)
        stop_det |=> (ack_o && idle_s));

    // R3: while idle the acknowledge pin is released
    a_r3_idle_released: assert property (@(posedge clk) disable iff (!rst_n)
        idle_s |-> ack_o);

    // R7: the pin moves only after a clock fall or a bus condition
    a_r7_ack_moves_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(ack_o) |-> $past(scl_fall || start_det || stop_det));

    // R9: an opening condition always leaves idle to take a device byte
    a_r9_start_restarts: assert property (@(posedge clk) disable iff (!rst_n)
        start_det |=> !idle_s);

endmodule

bind tw_serial_slave tw_serial_slave_chk #(.NUM_RW(NUM_RW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .ack_o     (ack_o),
    .wr_stb_o  (wr_stb_o),
    .wr_addr_o (wr_addr_o),
    .scl_fall  (scl_fall),
    .start_det (start_det),
    .stop_det  (stop_det),
    .idle_s    (idle_s)
);

// File: tb/sim_tw_serial_slave.sv
`timescale 1ns/1ps
module sim_tw_serial_slave;
    localparam int NUM_RW = 32;
    localparam int PH     = 10;

    logic                clk = 1'b0;
    logic                rst_n = 1'b0;
    logic                scl = 1'b1;
    logic                sda = 1'b1;
    logic                ack_o, wr_stb_o;
    logic [7:0]          wr_addr_o, wr_data_o, rd_addr_o, rd_data_i;
    logic [NUM_RW*8-1:0] cfg_o;

    int n_chk = 0;
    int n_err = 0;
    int stb_cnt = 0;
    logic [7:0] last_a = 8'h00;
    logic [7:0] last_d = 8'h00;
    bit finished = 0;

    always #2.5 clk = ~clk;

    // neighbour model for the read-only range
    assign rd_data_i = rd_addr_o ^ 8'h5A;

    tw_serial_slave #(.NUM_RW(NUM_RW)) u0 (
        .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda), .ack_o(ack_o),
        .wr_stb_o(wr_stb_o), .wr_addr_o(wr_addr_o), .wr_data_o(wr_data_o),
        .rd_addr_o(rd_addr_o), .rd_data_i(rd_data_i), .cfg_o(cfg_o)
    );

    always @(negedge clk) begin
        if (rst_n && wr_stb_o) begin
            stb_cnt++;
            last_a = wr_addr_o;
            last_d = wr_data_o;
        end
    end

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] reg_of(input int i);
        return cfg_o[i*8 +: 8];
    endfunction

    task automatic hold();
        repeat (PH) @(negedge clk);
    endtask

    task automatic half();
        repeat (PH/2) @(negedge clk);
    endtask

    task automatic bus_start();
        sda = 1'b1; hold();
        scl = 1'b1; hold();
        sda = 1'b0; hold();
        scl = 1'b0; hold();
    endtask

    task automatic bus_stop();
        sda = 1'b0; hold();
        scl = 1'b1; hold();
        sda = 1'b1; hold();
    endtask

    task automatic send_bits(input logic [7:0] b, input int n);
        for (int i = 0; i < n; i++) begin
            sda = b[7-i]; hold();
            scl = 1'b1;   hold();
            scl = 1'b0;
        end
    endtask

    task automatic send_byte(input logic [7:0] b, output logic a);
        send_bits(b, 8);
        sda = 1'b1; hold();
        scl = 1'b1; half();
        a = ack_o;  half();
        scl = 1'b0; hold();
    endtask

    task automatic recv_byte(input logic mack, output logic [7:0] d, output logic rel);
        for (int i = 0; i < 8; i++) begin
            hold();
            scl = 1'b1; half();
            d[7-i] = ~ack_o; half();
            scl = 1'b0;
        end
        hold();
        sda = mack; hold();
        scl = 1'b1; half();
        rel = ack_o; half();
        scl = 1'b0; hold();
        sda = 1'b1;
    endtask

    task automatic set_ptr(input logic [7:0] p);
        logic a;
        bus_start();
        send_byte(8'h24, a);
        send_byte(p, a);
        bus_stop();
    endtask

    task automatic t_reset();
        chk("R1 ack_o idle", {7'd0, ack_o}, 8'h01);
        chk("R1 no strobe", 8'(stb_cnt), 8'h00);
        chk("R1 reg0 default", reg_of(0), 8'h20);
        chk("R1 reg31 default", reg_of(31), 8'h3F);
    endtask

    task automatic t_write_burst();
        logic a;
        bus_start();
        send_byte(8'h24, a); chk("R3 write device ack", {7'd0, a}, 8'h00);
        send_byte(8'h04, a); chk("R4 pointer ack", {7'd0, a}, 8'h00);
        send_byte(8'hFF, a); chk("R4 data ack", {7'd0, a}, 8'h00);
        send_byte(8'h80, a);
        send_byte(8'hEE, a);
        bus_stop();
        chk("R5 reg4", reg_of(4), 8'hFF);
        chk("R5 reg5", reg_of(5), 8'h80);
        chk("R5 reg6", reg_of(6), 8'hEE);
        chk("R5 strobe count", 8'(stb_cnt), 8'd3);
        chk("R5 strobe addr", last_a, 8'h06);
        chk("R5 strobe data", last_d, 8'hEE);
        chk("R2 released after stop", {7'd0, ack_o}, 8'h01);
    endtask

    task automatic t_read_back();
        logic a, rel;
        logic [7:0] d;
        set_ptr(8'h04);
        bus_start();
        send_byte(8'h25, a); chk("R3 read device ack", {7'd0, a}, 8'h00);
        recv_byte(1'b0, d, rel); chk("R7 read reg4", d, 8'hFF);
        chk("R7 released in host ack slot", {7'd0, rel}, 8'h01);
        recv_byte(1'b0, d, rel); chk("R7 read reg5 msb first", d, 8'h80);
        recv_byte(1'b1, d, rel); chk("R7 read reg6", d, 8'hEE);
        for (int k = 0; k < 3; k++) begin
            hold(); scl = 1'b1; half();
            chk("R8 quiet after host nack", {7'd0, ack_o}, 8'h01);
            half(); scl = 1'b0;
        end
        hold();
        bus_stop();
    endtask

    task automatic t_bad_addr();
        logic a;
        int s0 = stb_cnt;
        bus_start();
        send_byte(8'h50, a); chk("R3 foreign device no ack", {7'd0, a}, 8'h01);
        send_byte(8'h00, a); chk("R3 following byte no ack", {7'd0, a}, 8'h01);
        send_byte(8'h55, a);
        bus_stop();
        chk("R3 reg0 untouched", reg_of(0), 8'h20);
        chk("R3 no strobe", 8'(stb_cnt - s0), 8'd0);
    endtask

    task automatic t_readonly_wrap();
        logic a;
        int s0 = stb_cnt;
        bus_start();
        send_byte(8'h24, a);
        send_byte(8'hFF, a);
        send_byte(8'h77, a); chk("R6 read-only write still acked", {7'd0, a}, 8'h00);
        chk("R6 no strobe for 0xFF", 8'(stb_cnt - s0), 8'd0);
        send_byte(8'h99, a);
        bus_stop();
        chk("R6 wrap to reg0", reg_of(0), 8'h99);
        chk("R6 wrap strobe addr", last_a, 8'h00);
        chk("R6 one strobe", 8'(stb_cnt - s0), 8'd1);
    endtask

    task automatic t_ext_read();
        logic a, rel;
        logic [7:0] d;
        set_ptr(8'h1F);
        bus_start();
        send_byte(8'h25, a);
        recv_byte(1'b0, d, rel); chk("R7 last bank reg", d, 8'h3F);
        recv_byte(1'b0, d, rel); chk("R7 external 0x20", d, 8'h7A);
        recv_byte(1'b1, d, rel); chk("R7 external 0x21", d, 8'h7B);
        bus_stop();
    endtask

    task automatic t_abort();
        logic a;
        bus_start();
        send_bits(8'h24, 4);
        bus_start();
        send_byte(8'h24, a); chk("R9 device ack after abort", {7'd0, a}, 8'h00);
        send_byte(8'h08, a);
        send_bits(8'hA5, 5);
        bus_start();
        send_byte(8'h24, a);
        send_byte(8'h08, a);
        send_byte(8'hC3, a);
        bus_stop();
        chk("R9 reg8 written", reg_of(8), 8'hC3);
        chk("R9 reg9 untouched", reg_of(9), 8'h29);
    endtask

    task automatic t_stop_mid();
        logic a;
        int s0 = stb_cnt;
        bus_start();
        send_byte(8'h24, a);
        send_byte(8'h0A, a);
        send_bits(8'hFF, 3);
        bus_stop();
        scl = 1'b0; hold();
        sda = 1'b0; hold();
        for (int k = 0; k < 9; k++) begin
            scl = 1'b1; half();
            chk("R2 idle after stop", {7'd0, ack_o}, 8'h01);
            half(); scl = 1'b0; hold();
        end
        sda = 1'b1; hold();
        scl = 1'b1; hold();
        chk("R2 reg10 untouched", reg_of(10), 8'h2A);
        chk("R2 no strobe", 8'(stb_cnt - s0), 8'd0);
    endtask

    task automatic summary();
        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_err);
        $finish;
    endtask

    initial begin
        repeat (10) @(negedge clk);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);
        t_reset();
        t_write_burst();
        t_read_back();
        t_bad_addr();
        t_readonly_wrap();
        t_ext_read();
        t_abort();
        t_stop_mid();
        finished = 1;
        summary();
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_err++;
            $display("FAIL watchdog actual=running expected=done");
            summary();
        end
    end

endmodule